// File: doc/BRIEF.md
# Digital Volume Soft-Ramp Controller

This block holds the current digital-volume code of an audio path and walks it toward a target code, so that gain changes never jump audibly. The code is 8 bits wide: code 0 is the loudest setting (+24 dB), each step up in code is 0.5 dB quieter, code 0x30 is unity gain, 0xFE is -103 dB and 0xFF means silence. The target is the user volume setting, or full mute (0xFF) while either a soft-mute request or an emergency request (clock failure, supply loss) is active.

At most one update happens per audio frame tick. Three ramp profiles exist: normal toward mute (code rising), normal toward loud (code falling), and emergency toward mute. Each profile has a 2-bit rate field and a 2-bit step field. The emergency profile wins whenever the emergency request is active. Once the emergency clears, the block ramps back using the normal toward-loud profile. The multiplier that applies the gain to the samples sits outside this block and takes `vol_cur` as its input.

Top module: `vol_ramp_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `vol_cur` to 0x30 and `ramp_done` to 0.
- R2: `vol_cur` changes only on a clock edge where `frame_tick` is high. Without a tick it holds its value.
- R3: The target is 0xFF while `mute_req` or `emerg_req` is high, and `vol_set` otherwise. When the target is above `vol_cur` (quieter), the code rises. When it is below, the code falls.
- R4: The step field of the active profile sets how far the code moves per update: 00 moves 8 codes (4 dB), 01 moves 4, 10 moves 2, and 11 moves 1 (0.5 dB).
- R5: The rate field of the active profile sets how often updates happen: 00 updates on every tick, 01 on every 2nd tick, 10 on every 4th tick, and 11 jumps straight to the target on the next tick.
- R6: The last update of a ramp lands exactly on the target and never passes it. A ramp toward mute ends at 0xFF and stays there.
- R7: While `emerg_req` is high, the ramp toward mute uses `em_rate`/`em_step` instead of `dn_rate`/`dn_step`, even if `mute_req` is also high.
- R8: After `emerg_req` falls with `mute_req` low, the code falls back toward `vol_set` using `up_rate`/`up_step`.
- R9: If `vol_set` changes during a ramp without changing the ramp direction, the new value is the target of the next update, and the tick count toward that update is kept.
- R10: The tick count restarts from zero whenever the ramp direction changes.
- R11: `ramp_done` is high in the cycle after an edge at which the updated `vol_cur` equals the target seen at that edge. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per audio frame |
| vol_set | input | 8 | User volume code |
| mute_req | input | 1 | Soft-mute request |
| emerg_req | input | 1 | Emergency mute request |
| up_rate | input | 2 | Rate field, normal ramp toward loud |
| up_step | input | 2 | Step field, normal ramp toward loud |
| dn_rate | input | 2 | Rate field, normal ramp toward mute |
| dn_step | input | 2 | Step field, normal ramp toward mute |
| em_rate | input | 2 | Rate field, emergency ramp |
| em_step | input | 2 | Step field, emergency ramp |
| vol_cur | output | 8 | Current volume code (registered) |
| ramp_done | output | 1 | Current code equals target (registered) |

## Verification
The assertions take it that all inputs are synchronous to `clk` and that `frame_tick` is a single-cycle pulse. They take it that the profile fields only change while no ramp step is being judged. The step-size bound holds only while no rate field selects an instant jump, and the property carries that condition itself. The done check only judges cycles in which `vol_set`, `mute_req` and `emerg_req` have held their values for a cycle. The stimulus drives every input on the falling clock edge. It pulses the tick for exactly one cycle, and it changes configuration fields only between ticks.

// File: rtl/vramp_pkg.sv
package vramp_pkg;
  localparam int RATE_W = 2;
  localparam int STEP_W = 2;
  localparam int NPROF  = 3;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    PRF_UP = 2'd0,
    PRF_DN = 2'd1,
    PRF_EM = 2'd2
  } prf_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [STEP_W-1:0] step;
  } prof_t;
endpackage

// File: rtl/vramp_sel.sv
module vramp_sel
  import vramp_pkg::*;
#(
  parameter int VOL_W = 8
) (
  input  logic [VOL_W-1:0] vol_cur,
  input  logic [VOL_W-1:0] vol_set,
  input  logic             mute_req,
  input  logic             emerg_req,
  output logic [VOL_W-1:0] target,
  output dir_e             dir,
  output prf_e             sel
);
  localparam logic [VOL_W-1:0] MUTE_CODE = '1;

  always_comb begin
    target = (mute_req || emerg_req) ? MUTE_CODE : vol_set;
    if (target > vol_cur)      dir = DIR_DN;
    else if (target < vol_cur) dir = DIR_UP;
    else                       dir = DIR_IDLE;
    if (emerg_req)             sel = PRF_EM;
    else if (dir == DIR_UP)    sel = PRF_UP;
    else                       sel = PRF_DN;
  end
endmodule

// File: rtl/vramp_decode.sv
module vramp_decode
  import vramp_pkg::*;
#(
  parameter int VOL_W = 8,
  parameter int DIV_W = 2
) (
  input  prof_t [NPROF-1:0] profs,
  input  prf_e              sel,
  output logic              instant,
  output logic [DIV_W-1:0]  term,
  output logic [VOL_W-1:0]  step_code
);
  localparam int STEP_MAX = (1 << STEP_W) - 1;

  logic             inst_a [NPROF];
  logic [DIV_W-1:0] term_a [NPROF];
  logic [VOL_W-1:0] stp_a  [NPROF];

  for (genvar g = 0; g < NPROF; g++) begin : g_prof
    assign inst_a[g] = (profs[g].rate == '1);
    assign term_a[g] = DIV_W'((32'd1 << profs[g].rate) - 32'd1);
    assign stp_a[g]  = VOL_W'(32'd1 << (STEP_MAX - int'(profs[g].step)));
  end

  assign instant   = inst_a[sel];
  assign term      = term_a[sel];
  assign step_code = stp_a[sel];
endmodule

// File: rtl/vramp_div.sv
module vramp_div
  import vramp_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  dir_e             dir,
  input  logic             instant,
  input  logic [DIV_W-1:0] term,
  output logic             fire
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] eff;
  dir_e             prev_dir;

  always_comb begin
    eff  = (dir != prev_dir || dir == DIR_IDLE) ? '0 : cnt;
    fire = tick && (dir != DIR_IDLE) && (instant || eff == term);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      prev_dir <= DIR_IDLE;
    end else begin
      prev_dir <= dir;
      if (fire)      cnt <= '0;
      else if (tick && dir != DIR_IDLE) cnt <= eff + 1'b1;
      else           cnt <= eff;
    end
  end
endmodule

// File: rtl/vramp_step.sv
module vramp_step
  import vramp_pkg::*;
#(
  parameter int VOL_W = 8
) (
  input  logic [VOL_W-1:0] cur,
  input  logic [VOL_W-1:0] target,
  input  dir_e             dir,
  input  logic             jump,
  input  logic [VOL_W-1:0] step_code,
  output logic [VOL_W-1:0] nxt
);
  logic [VOL_W:0] sum;
  logic [VOL_W-1:0] gap;

  always_comb begin
    sum = {1'b0, cur} + {1'b0, step_code};
    gap = (dir == DIR_DN) ? (target - cur) : (cur - target);
    if (jump || dir == DIR_IDLE)  nxt = jump ? target : cur;
    else if (gap <= step_code)    nxt = target;
    else if (dir == DIR_DN)       nxt = sum[VOL_W-1:0];
    else                          nxt = cur - step_code;
  end
endmodule

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl
  import vramp_pkg::*;
#(
  parameter int               VOL_W      = 8,
  parameter logic [VOL_W-1:0] RESET_CODE = 8'h30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic [VOL_W-1:0] vol_set,
  input  logic             mute_req,
  input  logic             emerg_req,
  input  logic [1:0]       up_rate,
  input  logic [1:0]       up_step,
  input  logic [1:0]       dn_rate,
  input  logic [1:0]       dn_step,
  input  logic [1:0]       em_rate,
  input  logic [1:0]       em_step,
  output logic [VOL_W-1:0] vol_cur,
  output logic             ramp_done
);
  localparam int DIV_W = ((1 << RATE_W) - 2) > 0 ? ((1 << RATE_W) - 2) : 1;

  prof_t [NPROF-1:0] profs;
  logic [VOL_W-1:0]  target, nxt, step_code;
  logic [DIV_W-1:0]  term;
  logic              instant, fire;
  dir_e              dir;
  prf_e              sel;

  assign profs[PRF_UP] = '{rate: up_rate, step: up_step};
  assign profs[PRF_DN] = '{rate: dn_rate, step: dn_step};
  assign profs[PRF_EM] = '{rate: em_rate, step: em_step};

  vramp_sel #(.VOL_W(VOL_W)) u_sel (
    .vol_cur(vol_cur), .vol_set(vol_set), .mute_req(mute_req),
    .emerg_req(emerg_req), .target(target), .dir(dir), .sel(sel)
  );

  vramp_decode #(.VOL_W(VOL_W), .DIV_W(DIV_W)) u_dec (
    .profs(profs), .sel(sel), .instant(instant), .term(term),
    .step_code(step_code)
  );

  vramp_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .tick(frame_tick), .dir(dir),
    .instant(instant), .term(term), .fire(fire)
  );

  vramp_step #(.VOL_W(VOL_W)) u_step (
    .cur(vol_cur), .target(target), .dir(dir), .jump(fire && instant),
    .step_code(step_code), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vol_cur   <= RESET_CODE;
      ramp_done <= 1'b0;
    end else begin
      if (fire) vol_cur <= nxt;
      ramp_done <= ((fire ? nxt : vol_cur) == target);
    end
  end
endmodule

// File: rtl/vramp_chk.sv
module vramp_chk #(
  parameter int               VOL_W      = 8,
  parameter logic [VOL_W-1:0] RESET_CODE = 8'h30
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_tick,
  input logic [VOL_W-1:0] vol_set,
  input logic             mute_req,
  input logic             emerg_req,
  input logic [1:0]       up_rate,
  input logic [1:0]       dn_rate,
  input logic [1:0]       em_rate,
  input logic [VOL_W-1:0] vol_cur,
  input logic             ramp_done
);
  localparam logic [VOL_W-1:0] MAX_STEP  = VOL_W'(8);
  localparam logic [VOL_W-1:0] MUTE_CODE = '1;

  AST_RESET_CODE: assert property (@(posedge clk)
    rst |=> (vol_cur == RESET_CODE && !ramp_done)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(vol_cur)); // R2

  AST_MUTE_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && (mute_req || emerg_req)) |=> (vol_cur >= $past(vol_cur))); // R3

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && up_rate != 2'b11 && dn_rate != 2'b11 && em_rate != 2'b11)
    |=> ((vol_cur >= $past(vol_cur)) ? (vol_cur - $past(vol_cur) <= MAX_STEP)
                                     : ($past(vol_cur) - vol_cur <= MAX_STEP))); // R4

  AST_MUTE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (emerg_req && vol_cur == MUTE_CODE) |=> (vol_cur == MUTE_CODE)); // R6

  AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ramp_done && !mute_req && !emerg_req && $stable(vol_set) &&
     $stable(mute_req) && $stable(emerg_req)) |-> (vol_cur == vol_set)); // R11
endmodule

bind vol_ramp_ctrl vramp_chk #(.VOL_W(VOL_W), .RESET_CODE(RESET_CODE)) u_chk (
  .clk(clk), .rst(rst), .frame_tick(frame_tick), .vol_set(vol_set),
  .mute_req(mute_req), .emerg_req(emerg_req), .up_rate(up_rate),
  .dn_rate(dn_rate), .em_rate(em_rate), .vol_cur(vol_cur),
  .ramp_done(ramp_done)
);

// File: tb/vol_ramp_ctrl_test.sv
module vol_ramp_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic [7:0] vol_set = 8'h30;
  logic       mute_req = 1'b0, emerg_req = 1'b0;
  logic [1:0] up_rate = 2'b00, up_step = 2'b11;
  logic [1:0] dn_rate = 2'b00, dn_step = 2'b11;
  logic [1:0] em_rate = 2'b00, em_step = 2'b11;
  logic [7:0] vol_cur;
  logic       ramp_done;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vol_ramp_ctrl uut (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .vol_set(vol_set),
    .mute_req(mute_req), .emerg_req(emerg_req),
    .up_rate(up_rate), .up_step(up_step), .dn_rate(dn_rate),
    .dn_step(dn_step), .em_rate(em_rate), .em_step(em_step),
    .vol_cur(vol_cur), .ramp_done(ramp_done)
  );

  task automatic check_vol(input string req, input logic [7:0] exp);
    n_cmp++;
    if (vol_cur !== exp) begin
      n_bad++;
      $display("FAIL %s vol_cur act=%h exp=%h", req, vol_cur, exp);
    end
  endtask

  task automatic check_done(input string req, input logic exp);
    n_cmp++;
    if (ramp_done !== exp) begin
      n_bad++;
      $display("FAIL %s ramp_done act=%b exp=%b", req, ramp_done, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; frame_tick = 1'b0; vol_set = 8'h30;
    mute_req = 1'b0; emerg_req = 1'b0;
    up_rate = 2'b00; up_step = 2'b11; dn_rate = 2'b00; dn_step = 2'b11;
    em_rate = 2'b00; em_step = 2'b11;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_vol("R1", 8'h30);
    check_done("R1", 1'b0);
    idle(1);
    check_done("R11", 1'b1);
  endtask

  task automatic t_hold();
    do_reset();
    vol_set = 8'h40;
    idle(5);
    check_vol("R2", 8'h30);
    tick();
    check_vol("R4", 8'h31);
    check_done("R11", 1'b0);
  endtask

  task automatic t_steps();
    do_reset();
    dn_step = 2'b00; vol_set = 8'h40;
    tick(); check_vol("R4", 8'h38);
    tick(); check_vol("R6", 8'h40);
    check_done("R11", 1'b1);
    dn_step = 2'b01; vol_set = 8'h50;
    tick(); check_vol("R4", 8'h44);
    dn_step = 2'b10;
    tick(); check_vol("R4", 8'h46);
    dn_step = 2'b00; vol_set = 8'h49;
    tick(); check_vol("R6", 8'h49);
  endtask

  task automatic t_rates();
    do_reset();
    dn_rate = 2'b01; vol_set = 8'h40;
    tick(); check_vol("R5", 8'h30);
    tick(); check_vol("R5", 8'h31);
    do_reset();
    dn_rate = 2'b10; vol_set = 8'h40;
    tick(); tick(); tick();
    check_vol("R5", 8'h30);
    tick(); check_vol("R5", 8'h31);
    do_reset();
    dn_rate = 2'b11; vol_set = 8'h40;
    tick(); check_vol("R5", 8'h40);
  endtask

  task automatic t_mute();
    do_reset();
    dn_step = 2'b00; mute_req = 1'b1;
    for (int i = 0; i < 25; i++) tick();
    check_vol("R3", 8'hF8);
    tick(); check_vol("R6", 8'hFF);
    check_done("R11", 1'b1);
    tick(); check_vol("R6", 8'hFF);
    mute_req = 1'b0; up_rate = 2'b11;
    tick(); check_vol("R3", 8'h30);
  endtask

  task automatic t_emerg();
    do_reset();
    dn_rate = 2'b10; em_step = 2'b01;
    mute_req = 1'b1; emerg_req = 1'b1;
    tick(); check_vol("R7", 8'h34);
    em_rate = 2'b11;
    tick(); check_vol("R7", 8'hFF);
    emerg_req = 1'b0; mute_req = 1'b0;
    up_rate = 2'b01; up_step = 2'b00;
    tick(); check_vol("R8", 8'hFF);
    tick(); check_vol("R8", 8'hF7);
  endtask

  task automatic t_retarget();
    do_reset();
    dn_rate = 2'b01; vol_set = 8'h40;
    tick(); check_vol("R9", 8'h30);
    vol_set = 8'h38;
    tick(); check_vol("R9", 8'h31);
  endtask

  task automatic t_dirchange();
    do_reset();
    dn_rate = 2'b01; up_rate = 2'b01; vol_set = 8'h40;
    tick(); tick(); check_vol("R10", 8'h31);
    tick();
    vol_set = 8'h20;
    tick(); check_vol("R10", 8'h31);
    tick(); check_vol("R10", 8'h30);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_steps();
    t_rates();
    t_mute();
    t_emerg();
    t_retarget();
    t_dirchange();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule